// File: doc/BRIEF.md
# Indexed Chipset Configuration Register File with Shadow Memory Routing

This block holds a chipset's configuration bytes behind an index/data port pair on an 8-bit I/O bus. Software writes a register number to the index port and then reads or writes the selected byte through the data port. Some registers mask certain bits on write. Register numbers in the top range belong to the processor, and the block does not answer for them.

Four control registers are decoded into routing attributes for the upper-memory area. Each 16 KB segment from C0000h to EFFFFh, and the single 64 KB segment at F0000h, independently sends its reads and its writes either to internal RAM or to the external bus. Two summary flags report any internal routing in the BIOS area (E0000h and up). A control bit reports whether SMRAM is visible in A0000h–BFFFFh. A combinational query port returns the routing attribute of any 20-bit memory address. The block only reports routing and never moves data.

Top module: `chipset_cfg_top`

## Requirements
- R1: An I/O write to address 0022h loads the index register. An I/O read of 0022h returns the current index.
- R2: An I/O write to 0023h stores the data byte in the register selected by the index. An I/O read of 0023h returns that register when the index is below C0h.
- R3: An I/O read of 0023h returns FFh whenever the index is C0h or above.
- R4: Write masks are applied: register 21h clears bit 0, 22h clears bit 7, 29h keeps bits 3:0 and 36h keeps bits 5:0. All other registers except 28h store the byte unchanged.
- R5: Register 28h is stored ANDed with E3h, and smram_en equals its bit 7.
- R6: Reset sets every register to 00h except register 7Bh, which becomes FFh, and sets the index to 00h.
- R7: For r in 0..2 and pair n in 0..3, register 25h+r controls segment k=4r+n, which covers C0000h+4000h*k. Bit 2n drives seg_wr_int[k] and bit 2n+1 drives seg_rd_int[k]. The outputs change in the clock cycle after the data write.
- R8: Bit 0 of register 28h drives seg_wr_int[12] and bit 1 drives seg_rd_int[12], which cover F0000h–FFFFFh.
- R9: bios_shadow_rd is the OR of seg_rd_int[12:8], and bios_shadow_wr is the OR of seg_wr_int[12:8]. These are the segments at E0000h and above.
- R10: query_attr returns {read_internal, write_internal} for the segment that holds query_addr, and 00 for any address below C0000h.
- R11: I/O writes to any other address change no state. I/O reads of any other address return FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational, 00h when io_rd is low) |
| seg_rd_int | output | 13 | Per-segment read routed to internal RAM |
| seg_wr_int | output | 13 | Per-segment write routed to internal RAM |
| bios_shadow_rd | output | 1 | Some segment at E0000h or above reads internally |
| bios_shadow_wr | output | 1 | Some segment at E0000h or above writes internally |
| smram_en | output | 1 | SMRAM visible in A0000h–BFFFFh |
| query_addr | input | 20 | Memory address to classify |
| query_attr | output | 2 | Bit 1 read internal, bit 0 write internal |

## Verification
The bench drives each masked register with FFh and compares the readback against a model. A missing or misplaced mask would return the wrong byte, and a wrong mask on 28h would also change smram_en or the F0000h attribute. Bit patterns that set the read and write bits apart are written to every shadow register, and a query is made at the start and the end of every segment. A swapped pair or an off-by-one segment boundary would then route the wrong half of the pair or the neighbouring segment. The bench also sets an index in the processor range, writes to an unrelated port and resets again in the middle of the run. These steps catch data leaking from the processor range, stray writes and a wrong reset value for 7Bh.

// File: rtl/chipset_cfg_pkg.sv
package chipset_cfg_pkg;
  localparam int REG_COUNT   = 256;
  localparam int SEG_SMALL   = 12;
  localparam int SEG_TOTAL   = SEG_SMALL + 1;
  localparam int BIOS_FIRST  = 8;

  localparam logic [7:0] R_MASK_A   = 8'h21;
  localparam logic [7:0] R_MASK_B   = 8'h22;
  localparam logic [7:0] R_SHADOW0  = 8'h25;
  localparam logic [7:0] R_SHADOW1  = 8'h26;
  localparam logic [7:0] R_SHADOW2  = 8'h27;
  localparam logic [7:0] R_TOPSEG   = 8'h28;
  localparam logic [7:0] R_MASK_C   = 8'h29;
  localparam logic [7:0] R_MASK_D   = 8'h36;
  localparam logic [7:0] R_ONES_RST = 8'h7B;

  // Bits kept when a data-port write lands on register idx.
  function automatic logic [7:0] keep_mask(input logic [7:0] idx);
    case (idx)
      R_MASK_A: keep_mask = 8'hFE;
      R_MASK_B: keep_mask = 8'h7F;
      R_TOPSEG: keep_mask = 8'hE3;
      R_MASK_C: keep_mask = 8'h0F;
      R_MASK_D: keep_mask = 8'h3F;
      default:  keep_mask = 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] reset_byte(input logic [7:0] idx);
    reset_byte = (idx == R_ONES_RST) ? 8'hFF : 8'h00;
  endfunction
endpackage

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import chipset_cfg_pkg::*;
#(
  parameter int               ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT = 16'h0022,
  parameter logic [ADDR_W-1:0] DAT_PORT = 16'h0023,
  parameter logic [7:0]        CPU_BASE = 8'hC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic [25:0]       shadow_ctrl,
  output logic              smram_en
);
  logic [7:0] regs [REG_COUNT];
  logic [7:0] idx_q;

  // Named events for the assertions
  logic idx_wr_ev, dat_wr_ev, cpu_range_rd_ev, stray_wr_ev;
  assign idx_wr_ev       = io_wr && (io_addr == IDX_PORT);
  assign dat_wr_ev       = io_wr && (io_addr == DAT_PORT);
  assign cpu_range_rd_ev = io_rd && (io_addr == DAT_PORT) && (idx_q >= CPU_BASE);
  assign stray_wr_ev     = io_wr && (io_addr != IDX_PORT) && (io_addr != DAT_PORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= 8'h00;
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= reset_byte(8'(i));
    end else if (idx_wr_ev) begin
      idx_q <= io_wdata;
    end else if (dat_wr_ev) begin
      regs[idx_q] <= io_wdata & keep_mask(idx_q);
    end
  end

  always_comb begin
    if (!io_rd)                     io_rdata = 8'h00;
    else if (io_addr == IDX_PORT)   io_rdata = idx_q;
    else if (io_addr == DAT_PORT)   io_rdata = (idx_q >= CPU_BASE) ? 8'hFF : regs[idx_q];
    else                            io_rdata = 8'hFF;
  end

  assign shadow_ctrl = {regs[R_TOPSEG][1:0], regs[R_SHADOW2], regs[R_SHADOW1], regs[R_SHADOW0]};
  assign smram_en    = regs[R_TOPSEG][7];

  // R1
  idx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr_ev |=> idx_q == $past(io_wdata));
  // R3
  cpu_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_range_rd_ev |-> io_rdata == 8'hFF);
  // R4
  mask_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr_ev && idx_q == R_MASK_A) |=> regs[R_MASK_A][0] == 1'b0);
  // R5
  smram_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr_ev && idx_q == R_TOPSEG) |=> smram_en == $past(io_wdata[7]));
  // R11
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stray_wr_ev |=> $stable(idx_q) && $stable(shadow_ctrl));
endmodule

// File: rtl/shadow_decode.sv
module shadow_decode
  import chipset_cfg_pkg::*;
(
  input  logic [25:0]          shadow_ctrl,
  output logic [SEG_TOTAL-1:0] rd_int,
  output logic [SEG_TOTAL-1:0] wr_int,
  output logic                 bios_rd,
  output logic                 bios_wr
);
  for (genvar k = 0; k < SEG_SMALL; k++) begin : g_small
    localparam int WBIT = (k / 4) * 8 + (k % 4) * 2;
    assign wr_int[k] = shadow_ctrl[WBIT];
    assign rd_int[k] = shadow_ctrl[WBIT + 1];
  end
  assign wr_int[SEG_SMALL] = shadow_ctrl[24];
  assign rd_int[SEG_SMALL] = shadow_ctrl[25];

  assign bios_rd = |rd_int[SEG_TOTAL-1:BIOS_FIRST];
  assign bios_wr = |wr_int[SEG_TOTAL-1:BIOS_FIRST];
endmodule

// File: rtl/seg_lookup.sv
module seg_lookup
  import chipset_cfg_pkg::*;
(
  input  logic [19:0]          addr,
  input  logic [SEG_TOTAL-1:0] rd_int,
  input  logic [SEG_TOTAL-1:0] wr_int,
  output logic [1:0]           attr
);
  localparam logic [19:0] LOW_EDGE = 20'hC0000;
  localparam logic [19:0] TOP_EDGE = 20'hF0000;
  logic [3:0] slot;
  assign slot = addr[17:14];

  always_comb begin
    if (addr < LOW_EDGE)       attr = 2'b00;
    else if (addr >= TOP_EDGE) attr = {rd_int[SEG_SMALL], wr_int[SEG_SMALL]};
    else                       attr = {rd_int[slot], wr_int[slot]};
  end
endmodule

// File: rtl/chipset_cfg_top.sv
module chipset_cfg_top
  import chipset_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic [12:0] seg_rd_int,
  output logic [12:0] seg_wr_int,
  output logic        bios_shadow_rd,
  output logic        bios_shadow_wr,
  output logic        smram_en,
  input  logic [19:0] query_addr,
  output logic [1:0]  query_attr
);
  logic [25:0] shadow_ctrl;

  cfg_regfile #(.ADDR_W(16)) u_regs (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .shadow_ctrl(shadow_ctrl), .smram_en(smram_en)
  );

  shadow_decode u_dec (
    .shadow_ctrl(shadow_ctrl), .rd_int(seg_rd_int), .wr_int(seg_wr_int),
    .bios_rd(bios_shadow_rd), .bios_wr(bios_shadow_wr)
  );

  seg_lookup u_look (
    .addr(query_addr), .rd_int(seg_rd_int), .wr_int(seg_wr_int), .attr(query_attr)
  );

  // R10
  low_query_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (query_addr < 20'hC0000) |-> query_attr == 2'b00);
  // R8
  top_query_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (query_addr[19:16] == 4'hF) |-> query_attr == {seg_rd_int[12], seg_wr_int[12]});
  // R9
  bios_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bios_shadow_rd, 1'b0}) && (bios_shadow_rd || seg_rd_int[12:8] == 5'd0));
endmodule

// File: tb/chipset_cfg_top_tb_top.sv
`timescale 1ns/1ps
module chipset_cfg_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h0;
  logic [7:0]  io_rdata;
  logic [12:0] seg_rd_int, seg_wr_int;
  logic        bios_shadow_rd, bios_shadow_wr, smram_en;
  logic [19:0] query_addr = 20'h0;
  logic [1:0]  query_attr;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] m_regs [256];
  logic [7:0] m_idx;

  always #5 clk = ~clk;

  chipset_cfg_top dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .seg_rd_int(seg_rd_int), .seg_wr_int(seg_wr_int),
    .bios_shadow_rd(bios_shadow_rd), .bios_shadow_wr(bios_shadow_wr), .smram_en(smram_en),
    .query_addr(query_addr), .query_attr(query_attr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_mask(input logic [7:0] i, input logic [7:0] v);
    if (i == 8'h21) return v & 8'b1111_1110;
    if (i == 8'h22) return v & 8'b0111_1111;
    if (i == 8'h28) return v & 8'b1110_0011;
    if (i == 8'h29) return v & 8'b0000_1111;
    if (i == 8'h36) return v & 8'b0011_1111;
    return v;
  endfunction

  function automatic logic m_seg(input int k, input bit rd);
    if (k == 12) return m_regs[8'h28][rd ? 1 : 0];
    return m_regs[8'h25 + k / 4][2 * (k % 4) + (rd ? 1 : 0)];
  endfunction

  function automatic logic [1:0] m_query(input logic [19:0] a);
    int k;
    if (a < 20'hC0000) return 2'b00;
    if (a >= 20'hF0000) k = 12;
    else k = (int'(a) - 'hC0000) / 'h4000;
    return {m_seg(k, 1), m_seg(k, 0)};
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 256; i++) m_regs[i] = (i == 'h7B) ? 8'hFF : 8'h00;
    m_idx = 8'h00;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1;
    io_wr = 1'b0;
    if (a == 16'h0022) m_idx = d;
    else if (a == 16'h0023) m_regs[m_idx] = m_mask(m_idx, d);
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #2 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic reg_check(input string req, input logic [7:0] idx);
    logic [7:0] v;
    io_write(16'h0022, idx);
    io_read(16'h0023, v);
    chk(req, v, (idx >= 8'hC0) ? 8'hFF : m_regs[idx]);
  endtask

  task automatic query_check(input string req, input logic [19:0] a);
    @(negedge clk);
    query_addr = a;
    #1 chk(req, query_attr, m_query(a));
  endtask

  // Per-cycle comparison of routing outputs against the model (R7 R8 R9 R5)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [12:0] er, ew;
      for (int k = 0; k < 13; k++) begin er[k] = m_seg(k, 1); ew[k] = m_seg(k, 0); end
      chk("R7 seg_rd_int", seg_rd_int, er);
      chk("R7 seg_wr_int", seg_wr_int, ew);
      chk("R9 bios_rd", bios_shadow_rd, |er[12:8]);
      chk("R9 bios_wr", bios_shadow_wr, |ew[12:8]);
      chk("R5 smram_en", smram_en, m_regs[8'h28][7]);
    end
  end

  initial begin
    #200000;
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    m_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R6 reset values
    io_read(16'h0022, v); chk("R6 index", v, 8'h00);
    reg_check("R6 reg7B", 8'h7B);
    reg_check("R6 reg25", 8'h25);
    reg_check("R6 reg00", 8'h00);

    // R1 index readback
    io_write(16'h0022, 8'h9C);
    io_read(16'h0022, v); chk("R1 index", v, 8'h9C);

    // R2 plain register
    io_write(16'h0022, 8'h40); io_write(16'h0023, 8'h5A);
    reg_check("R2 reg40", 8'h40);
    io_write(16'h0022, 8'h30); io_write(16'h0023, 8'hFF);
    reg_check("R2 reg30", 8'h30);

    // R4 masks
    foreach (m_regs[i]) begin end
    io_write(16'h0022, 8'h21); io_write(16'h0023, 8'hFF); reg_check("R4 reg21", 8'h21);
    io_write(16'h0022, 8'h22); io_write(16'h0023, 8'hFF); reg_check("R4 reg22", 8'h22);
    io_write(16'h0022, 8'h29); io_write(16'h0023, 8'hFF); reg_check("R4 reg29", 8'h29);
    io_write(16'h0022, 8'h36); io_write(16'h0023, 8'hFF); reg_check("R4 reg36", 8'h36);

    // R5 R8 register 28h
    io_write(16'h0022, 8'h28); io_write(16'h0023, 8'hFF); reg_check("R5 reg28", 8'h28);
    chk("R5 smram set", smram_en, 1'b1);
    query_check("R8 F0000", 20'hF0000);
    query_check("R8 FFFFF", 20'hFFFFF);
    io_write(16'h0022, 8'h28); io_write(16'h0023, 8'h02);
    chk("R5 smram clear", smram_en, 1'b0);
    query_check("R8 F8000 rd only", 20'hF8000);

    // R7 R10 distinct patterns per shadow register
    io_write(16'h0022, 8'h25); io_write(16'h0023, 8'b1001_1100);
    io_write(16'h0022, 8'h26); io_write(16'h0023, 8'b0110_0011);
    io_write(16'h0022, 8'h27); io_write(16'h0023, 8'b1000_0100);
    for (int k = 0; k < 12; k++) begin
      query_check("R10 seg start", 20'hC0000 + 20'(k * 'h4000));
      query_check("R10 seg end", 20'hC0000 + 20'(k * 'h4000 + 'h3FFF));
    end
    query_check("R10 below", 20'hBFFFF);
    query_check("R10 zero", 20'h00000);
    io_write(16'h0022, 8'h28); io_write(16'h0023, 8'h00);
    io_write(16'h0022, 8'h27); io_write(16'h0023, 8'h00);
    chk("R9 bios_rd off", bios_shadow_rd, 1'b0);
    io_write(16'h0022, 8'h27); io_write(16'h0023, 8'b0100_0000);
    chk("R9 bios_wr on", {bios_shadow_rd, bios_shadow_wr}, 2'b01);

    // R3 processor range
    io_write(16'h0022, 8'hC5); io_write(16'h0023, 8'hAA);
    reg_check("R3 regC5", 8'hC5);
    io_write(16'h0022, 8'hFF); reg_check("R3 regFF", 8'hFF);

    // R11 stray port
    io_write(16'h0022, 8'h25);
    io_write(16'h0080, 8'h77);
    io_read(16'h0022, v); chk("R11 index kept", v, 8'h25);
    io_read(16'h0080, v); chk("R11 stray read", v, 8'hFF);
    reg_check("R11 reg25 kept", 8'h25);

    // R6 second reset
    @(negedge clk); rst_n = 1'b0; m_reset();
    @(negedge clk); rst_n = 1'b1;
    reg_check("R6 reg7B again", 8'h7B);
    reg_check("R6 reg26 again", 8'h26);

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule